// File: doc/BRIEF.md
# Preloadable Timer and Event Counter

This block is an up-counter that counts in one of three ways. As a timer it counts pulses of an internal clock enable. As an event counter it counts rising edges of an external input. As a pulse-width meter it counts clock-enable pulses while the external input is held high. When the count passes its all-ones value, the counter reloads from a preload register. The same cycle sets a sticky overflow flag and fires a one-cycle wake strobe. An interrupt request follows the flag, gated by an enable bit.

Software reaches the block through a small register-mapped port. Address 0 writes the preload value and reads the live count. Address 1 holds the control word. Address 2 reads back the preload register. While the counter is stopped, a preload write also loads the counter. While it runs, the counter carries on from its current value. A read of the count freezes counting for that cycle. After a pulse-width measurement finishes, the block stops itself.

Top module: `preload_timer`

## Requirements
- R1: After reset the count, the preload register and the control word all read 0, and irqReq is low.
- R2: With the run bit (control bit 2) at 0, a write to address 0 sets both the preload register and the count to the written value. The new count is readable on the next cycle.
- R3: With the run bit at 1, a write to address 0 changes only the preload register (read back at address 2). The count carries on unchanged by the write.
- R4: When an increment occurs at the all-ones count, the count takes the preload value in that same cycle, and control bit 4 (overflow flag) becomes 1.
- R5: In timer mode (control bits 1:0 = 10) with run at 1, the count rises by one on each cycle in which tickEn is high.
- R6: In event mode (bits 1:0 = 01) with run at 1, the count rises by one per rising edge of extIn. The edge is seen through a two-stage synchroniser.
- R7: In pulse-width mode (bits 1:0 = 11), a synchronised rising edge of extIn arms the measurement. Each later tickEn cycle with extIn still high adds one. The synchronised falling edge ends the measurement and clears the run bit.
- R8: In timer and event modes, the run bit stays at 1 until software writes it, including across overflows.
- R9: wakeStrobe is high for exactly the cycle after each overflow increment, in every mode.
- R10: irqReq is high exactly when the overflow flag and the interrupt-enable bit (control bit 3) are both 1. The flag stays set until a control write with bit 4 at 1 clears it.
- R11: In a cycle where busRd is high at address 0, no increment takes place, so that count event is lost.
- R12: With mode bits 00, the count does not change while run is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Internal clock enable used in timer and pulse-width modes |
| extIn | input | 1 | Asynchronous external event or pulse input |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe; at address 0 it freezes counting |
| busAddr | input | ADDR_W | Register address: 0 count/preload, 1 control, 2 preload readback |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, valid in the same cycle |
| irqReq | output | 1 | Overflow interrupt request |
| wakeStrobe | output | 1 | One-cycle pulse after each overflow |

## Verification
The bench runs a count up to all-ones and checks that the reload picks up the preload value. A design that wrapped to zero would show the wrong count after overflow. It writes the preload register both while the counter is stopped and while it runs. A design that ignored the run bit would jump the live count in the running case. It holds the count address under read while ticks arrive, which catches a design that does not freeze. In pulse-width mode it places the start and end edges so the expected count depends on the exact synchroniser latency and on the run bit clearing itself. An off-by-one stage or a missing stop would give a count that differs by one, or a run bit that stays set.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmrMode_e;

  // control word bit positions
  localparam int unsigned CTL_MODE_LO = 0;
  localparam int unsigned CTL_RUN     = 2;
  localparam int unsigned CTL_IEN     = 3;
  localparam int unsigned CTL_FLAG    = 4;
  localparam int unsigned CTL_USED_W  = 5;

  typedef struct packed {
    logic incr;     // advance the count this cycle
    logic loadPre;  // capture write data into preload
    logic loadCnt;  // capture write data into count
  } dpStrobe_t;
endpackage

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  logic                  extIn,
  input  logic                  ctrlWr,
  input  logic [CTL_USED_W-1:0] ctrlWdata,
  input  logic                  preWr,
  input  logic                  cntRd,
  input  logic                  cntAtMax,
  output dpStrobe_t             strobe,
  output tmrMode_e              mode,
  output logic                  runBit,
  output logic                  ienBit,
  output logic                  ovfFlag,
  output logic                  wakeStrobe
);
  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] syncChain;
  logic syncLvl, prevLvl, riseEdge, fallEdge;
  logic armed, countEvt, incr, pwDone, overflow, flagClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[CHAIN_W-2:0], extIn};
  end

  assign syncLvl  = syncChain[SYNC_STAGES-1];
  assign prevLvl  = syncChain[SYNC_STAGES];
  assign riseEdge = syncLvl & ~prevLvl;
  assign fallEdge = ~syncLvl & prevLvl;

  always_comb begin
    case (mode)
      MODE_EVENT: countEvt = riseEdge;
      MODE_TIMER: countEvt = tickEn;
      MODE_PULSE: countEvt = armed & syncLvl & tickEn;
      default:    countEvt = 1'b0;
    endcase
  end

  assign incr     = runBit & ~cntRd & countEvt;
  assign overflow = incr & cntAtMax;
  assign pwDone   = runBit & (mode == MODE_PULSE) & armed & fallEdge;
  assign flagClr  = ctrlWr & ctrlWdata[CTL_FLAG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= MODE_OFF;
      runBit <= 1'b0;
      ienBit <= 1'b0;
    end else if (ctrlWr) begin
      mode   <= tmrMode_e'(ctrlWdata[CTL_MODE_LO +: 2]);
      runBit <= ctrlWdata[CTL_RUN];
      ienBit <= ctrlWdata[CTL_IEN];
    end else if (pwDone) begin
      runBit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         armed <= 1'b0;
    else if (!runBit || mode != MODE_PULSE || ctrlWr)  armed <= 1'b0;
    else if (riseEdge)                                 armed <= 1'b1;
    else if (fallEdge)                                 armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag    <= 1'b0;
      wakeStrobe <= 1'b0;
    end else begin
      ovfFlag    <= (ovfFlag & ~flagClr) | overflow;
      wakeStrobe <= overflow;
    end
  end

  always_comb begin
    strobe.incr    = incr;
    strobe.loadPre = preWr;
    strobe.loadCnt = preWr & ~runBit;
  end
endmodule

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cntVal,
  output logic [DATA_W-1:0] preVal,
  output logic              cntAtMax
);
  assign cntAtMax = &cntVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntVal <= '0;
    else if (strobe.loadCnt) cntVal <= wdata;
    else if (strobe.incr)    cntVal <= cntAtMax ? preVal : cntVal + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               preVal <= '0;
    else if (strobe.loadPre) preVal <= wdata;
  end
endmodule

// File: rtl/preload_timer.sv
module preload_timer
  import ptmr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              extIn,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqReq,
  output logic              wakeStrobe
);
  localparam logic [ADDR_W-1:0] ADDR_CNT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_PRE  = ADDR_W'(2);

  dpStrobe_t         strobe;
  tmrMode_e          mode;
  logic              runBit, ienBit, ovfFlag, cntAtMax;
  logic [DATA_W-1:0] cntVal, preVal, ctrlView;

  logic selCnt, selCtrl;
  assign selCnt  = (busAddr == ADDR_CNT);
  assign selCtrl = (busAddr == ADDR_CTRL);

  ptmr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extIn(extIn),
    .ctrlWr(busWr & selCtrl), .ctrlWdata(busWdata[CTL_USED_W-1:0]),
    .preWr(busWr & selCnt), .cntRd(busRd & selCnt), .cntAtMax(cntAtMax),
    .strobe(strobe), .mode(mode), .runBit(runBit), .ienBit(ienBit),
    .ovfFlag(ovfFlag), .wakeStrobe(wakeStrobe)
  );

  ptmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata),
    .cntVal(cntVal), .preVal(preVal), .cntAtMax(cntAtMax)
  );

  assign irqReq = ovfFlag & ienBit;

  always_comb begin
    ctrlView = '0;
    ctrlView[CTL_MODE_LO +: 2] = mode;
    ctrlView[CTL_RUN]  = runBit;
    ctrlView[CTL_IEN]  = ienBit;
    ctrlView[CTL_FLAG] = ovfFlag;
  end

  always_comb begin
    if (selCnt)                 busRdata = cntVal;
    else if (selCtrl)           busRdata = ctrlView;
    else if (busAddr == ADDR_PRE) busRdata = preVal;
    else                        busRdata = '0;
  end
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
  import ptmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              busRd,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              irqReq,
  input logic              wakeStrobe,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] preReg,
  input logic              runBit,
  input logic              ienBit,
  input logic              ovfFlag,
  input tmrMode_e          mode
);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);

  assert_stopped_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_CNT && !runBit) |=> cnt == $past(busWdata));

  assert_preload_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_CNT) |=> preReg == $past(busWdata));

  assert_run_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && (mode == MODE_EVENT || mode == MODE_TIMER) && !(busWr && busAddr == A_CTRL))
      |=> runBit);

  assert_wake_sets_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    wakeStrobe |-> ovfFlag);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (ienBit && ovfFlag));

  assert_read_freeze_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == A_CNT && !busWr) |=> cnt == $past(cnt));

  assert_off_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && mode == MODE_OFF && !busWr) |=> $stable(cnt));
endmodule

bind preload_timer ptmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
  .busWdata(busWdata), .irqReq(irqReq), .wakeStrobe(wakeStrobe),
  .cnt(cntVal), .preReg(preVal), .runBit(runBit), .ienBit(ienBit),
  .ovfFlag(ovfFlag), .mode(mode)
);

// File: tb/test_preload_timer.sv
module test_preload_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0, extIn = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       irqReq, wakeStrobe;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  preload_timer i_preload_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extIn(extIn),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqReq(irqReq), .wakeStrobe(wakeStrobe)
  );

  // behavioural reference model
  int mCnt, mPre, mMode, mRun, mIen, mFlag, mArm, mWake;
  bit hist[$];

  function automatic int expRd(input int a);
    case (a)
      0: return mCnt;
      1: return mMode + 4*mRun + 8*mIen + 16*mFlag;
      2: return mPre;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mPre = 0; mMode = 0; mRun = 0; mIen = 0; mFlag = 0; mArm = 0; mWake = 0;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      bit s2, s3, rise, fall, evt, inc, ovf, done, ctlW, cntW;
      int nCnt, nRun, nArm;
      s2 = hist[1]; s3 = hist[2];
      rise = s2 && !s3; fall = !s2 && s3;
      ctlW = busWr && busAddr == 2'd1;
      cntW = busWr && busAddr == 2'd0;
      evt = (mMode == 1 && rise) || (mMode == 2 && tickEn) ||
            (mMode == 3 && mArm != 0 && s2 && tickEn);
      inc = (mRun != 0) && !(busRd && busAddr == 2'd0) && evt;
      ovf = inc && mCnt == 255;
      done = mRun != 0 && mMode == 3 && mArm != 0 && fall;
      nCnt = mCnt;
      if (cntW && mRun == 0) nCnt = busWdata;
      else if (inc) nCnt = ovf ? mPre : mCnt + 1;
      if (mRun == 0 || mMode != 3 || ctlW) nArm = 0;
      else if (rise) nArm = 1;
      else if (fall) nArm = 0;
      else nArm = mArm;
      nRun = done ? 0 : mRun;
      mFlag = ((mFlag != 0 && !(ctlW && busWdata[4])) || ovf) ? 1 : 0;
      mWake = ovf ? 1 : 0;
      if (cntW) mPre = busWdata;
      if (ctlW) begin
        mMode = busWdata[1:0]; nRun = busWdata[2]; mIen = busWdata[3];
      end
      mCnt = nCnt; mRun = nRun; mArm = nArm;
      hist.push_front(extIn);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R4 R5 register read path", busRdata, expRd(busAddr));
      chk("R10 irqReq", irqReq, mFlag & mIen);
      chk("R9 wakeStrobe", wakeStrobe, mWake);
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    step();
    busWr = 1'b0;
  endtask

  task automatic rdChk(input logic [1:0] a, input int exp, input string tag);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    chk(tag, busRdata, exp);
    step();
    busRd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();
    // R1 reset state
    rdChk(2'd0, 8'h00, "R1 count");
    rdChk(2'd1, 8'h00, "R1 control");
    rdChk(2'd2, 8'h00, "R1 preload");
    chk("R1 irq", irqReq, 0);

    // R2 stopped preload write loads count
    wr(2'd0, 8'h5A);
    rdChk(2'd0, 8'h5A, "R2 count loaded");

    // R5 timer counts tickEn
    wr(2'd1, 8'h06);
    tickEn = 1'b1;
    repeat (10) @(posedge clk);
    #1 tickEn = 1'b0;
    rdChk(2'd0, 8'h64, "R5 timer count");

    // R3 running preload write leaves count
    wr(2'd0, 8'h20);
    rdChk(2'd2, 8'h20, "R3 preload updated");
    rdChk(2'd0, 8'h64, "R3 count untouched");

    // R4 overflow reload, flag, irq, R8 run stays
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFE);
    wr(2'd1, 8'h0E);
    tickEn = 1'b1;
    repeat (2) @(posedge clk);
    #1 tickEn = 1'b0;
    rdChk(2'd0, 8'hFE, "R4 reload value");
    rdChk(2'd1, 8'h1E, "R4 R8 flag set run kept");
    chk("R10 irq raised", irqReq, 1);

    // R10 clear flag, overflow with interrupt disabled
    wr(2'd1, 8'h16);
    chk("R10 flag cleared irq low", irqReq, 0);
    tickEn = 1'b1;
    repeat (2) @(posedge clk);
    #1 tickEn = 1'b0;
    rdChk(2'd1, 8'h16, "R10 flag sticky with ien off");
    chk("R10 no irq when disabled", irqReq, 0);

    // R11 read freezes counting
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h30);
    wr(2'd1, 8'h06);
    busAddr = 2'd0; busRd = 1'b1; tickEn = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R11 frozen under read", busRdata, 8'h30);
    @(posedge clk); #1 busRd = 1'b0;
    repeat (3) @(posedge clk);
    #1 tickEn = 1'b0;
    rdChk(2'd0, 8'h33, "R11 counting resumes");

    // R6 event counting of synchronised rising edges
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h15);
    for (int p = 0; p < 3; p++) begin
      extIn = 1'b1; repeat (3) step();
      extIn = 1'b0; repeat (3) step();
    end
    repeat (4) step();
    rdChk(2'd0, 8'h03, "R6 three edges counted");
    rdChk(2'd1, 8'h05, "R8 run held in event mode");

    // R7 pulse-width measurement and self stop
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h17);
    tickEn = 1'b1;
    repeat (2) step();
    extIn = 1'b1;
    repeat (8) @(posedge clk);
    #1 extIn = 1'b0;
    repeat (5) step();
    tickEn = 1'b0;
    rdChk(2'd0, 8'h07, "R7 pulse width count");
    rdChk(2'd1, 8'h03, "R7 run cleared");

    // R12 mode off does not count
    wr(2'd1, 8'h04);
    tickEn = 1'b1;
    extIn = 1'b1; repeat (3) step();
    extIn = 1'b0; repeat (3) step();
    tickEn = 1'b0;
    rdChk(2'd0, 8'h07, "R12 count unchanged");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule